// File: doc/BRIEF.md
# Keypad Strobe Timing Generator

This block drives the column strobes of a keypad matrix from an oscillator clock and reports key activity to a host. Eight strobe lines are raised one at a time. Each line stays high for one slot, and eight slots make up one scan cycle. The slot length is set by a 2-bit period select and a line-mode bit. The line-mode bit doubles every length. A slot is therefore always exactly one eighth of a scan cycle.

The key return lines are examined once per slot, in its last clock. If any return line is high at that moment, a sticky key-seen flag is set. An active-low interrupt output follows that flag whenever the interrupt enable is high. The flag stays set until the host pulses a clear input.

Configuration written while a scan cycle is running is held back and applied when that cycle ends. A cycle therefore never mixes two slot lengths.

Top module: `keyscan_gen`

## Requirements
- R1: While reset is high, and in the first clock after it falls, strobe line 0 alone is high, key_seen is 0 and irq_n is 1. Reset is synchronous and active high. The configuration present during reset is used for the first scan cycle.
- R2: Exactly one strobe line is high in every clock. The lines step in ascending order from line 0 (strobe bit 0) to line 7 (strobe bit 7), then return to line 0.
- R3: With long_mode = 0, each strobe line is held for 20, 40, 80 or 160 clocks when cyc_sel is 0, 1, 2 or 3.
- R4: With long_mode = 1, each strobe line is held for 40, 80, 160 or 320 clocks for the same cyc_sel codes, which is twice the long_mode = 0 length.
- R5: One scan cycle covers all eight lines and lasts eight slot lengths: 160 to 1280 clocks in mode 0, and 320 to 2560 clocks in mode 1.
- R6: cyc_sel and long_mode are captured only in the last clock of the line-7 slot. A change made in the middle of a cycle leaves the slot lengths of the rest of that cycle unchanged and applies from the next line-0 slot.
- R7: key_ret is sampled in the last clock of every slot. If any bit is 1 there, key_seen is 1 from the next clock on.
- R8: A key_ret value present in any other clock of a slot has no effect on key_seen.
- R9: key_seen stays 1 until irq_clr is high at a clock edge, and it is 0 from the next clock on. A detection in the same clock as irq_clr takes priority, so the flag stays 1.
- R10: irq_n is 0 exactly when key_seen is 1 and irq_en is 1. irq_en acts without delay, and it does not affect key_seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_sel | input | 2 | Scan period select code |
| long_mode | input | 1 | Doubles every slot and cycle length when 1 |
| irq_en | input | 1 | Interrupt output enable |
| irq_clr | input | 1 | Clears the key-seen flag |
| key_ret | input | 4 | Sampled key return lines, active high |
| strobe | output | 8 | One-hot strobe lines |
| irq_n | output | 1 | Interrupt, active low |
| key_seen | output | 1 | Latched key-detected flag |

## Verification
Scan timing is measured by counting the clocks each strobe line holds, over cycles that use randomly chosen period codes in both line modes. A new random code is written during line 3 of every cycle. This shows that lines 3 to 7 keep the old length and that the next cycle takes the new one, which separates capture at the cycle boundary from immediate capture. Detection is first exercised with directed pulses: one in mid-slot, one in the last clock of a slot, and one on the same clock as a clear. It is then exercised with random return-line traffic, clear pulses and enable toggles. A bench model of the sticky flag tells apart sampling at the slot end, sampling at other clocks, and the order of detection versus clear.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

    localparam int SEL_W        = 2;
    localparam int DEF_STROBES  = 8;
    localparam int DEF_BASE     = 20;
    localparam int DEF_RET_W    = 4;

    // period select plus the doubling bit
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             long_mode;
    } scan_cfg_t;

    // largest shift any configuration can apply to the base slot
    localparam int MAX_SHIFT = (1 << SEL_W);

    function automatic int unsigned slot_clocks(input int unsigned base, input scan_cfg_t c);
        int unsigned sh;
        sh = int'(c.sel) + int'(c.long_mode);
        return base << sh;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned base);
        return $clog2(base << MAX_SHIFT);
    endfunction

endpackage

// File: rtl/ks_cfg_stage.sv
module ks_cfg_stage
    import keyscan_pkg::*;
#(
    parameter int BASE_SLOT = DEF_BASE,
    parameter int CNT_W     = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  scan_cfg_t        cfg_in,
    input  logic             cycle_end,
    output scan_cfg_t        cfg_act,
    output logic [CNT_W-1:0] slot_last
);

    scan_cfg_t cfg_q;

    // capture only at reset or at the boundary between scan cycles
    always_ff @(posedge clk) begin
        if (rst || cycle_end) begin
            cfg_q <= cfg_in;
        end
    end

    assign cfg_act   = cfg_q;
    assign slot_last = CNT_W'(slot_clocks(BASE_SLOT, cfg_q) - 1);

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (!$past(cycle_end) && !$past(rst)) |-> $stable(cfg_act)); // R6

endmodule

// File: rtl/ks_slot_timer.sv
module ks_slot_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] slot_last,
    output logic             slot_end
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (slot_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign slot_end = (cnt == slot_last);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= slot_last); // R3

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        slot_end |=> (cnt == '0)); // R4

endmodule

// File: rtl/ks_strobe_ring.sv
module ks_strobe_ring #(
    parameter int STROBES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slot_end,
    output logic [STROBES-1:0] strobe,
    output logic               cycle_end
);

    localparam int IDX_W = $clog2(STROBES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STROBES - 1);

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (slot_end) begin
            idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
        end
    end

    for (genvar g = 0; g < STROBES; g++) begin : g_line
        assign strobe[g] = (idx == IDX_W'(g));
    end

    assign cycle_end = slot_end && (idx == LAST_IDX);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $countones(strobe) == 1); // R2

    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !slot_end |=> $stable(strobe)); // R3

    AST_RING_STEP: assert property (@(posedge clk) disable iff (rst)
        (slot_end && !strobe[STROBES-1]) |=> (strobe == ($past(strobe) << 1))); // R2

    AST_RING_WRAP: assert property (@(posedge clk) disable iff (rst)
        cycle_end |=> strobe[0]); // R5

endmodule

// File: rtl/ks_key_latch.sv
module ks_key_latch #(
    parameter int RET_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_end,
    input  logic [RET_W-1:0] key_ret,
    input  logic             irq_clr,
    input  logic             irq_en,
    output logic             key_seen,
    output logic             irq_n
);

    logic flag;
    logic hit;

    assign hit = slot_end && (|key_ret);

    // detection outranks clear so a press is never dropped
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (irq_clr) begin
            flag <= 1'b0;
        end
    end

    assign key_seen = flag;
    assign irq_n    = ~(flag & irq_en);

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (slot_end && (|key_ret)) |=> key_seen); // R7

    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
        (key_seen && !irq_clr) |=> key_seen); // R9

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!key_seen && !slot_end) |=> !key_seen); // R8

endmodule

// File: rtl/keyscan_gen.sv
module keyscan_gen
    import keyscan_pkg::*;
#(
    parameter int STROBES   = DEF_STROBES,
    parameter int BASE_SLOT = DEF_BASE,
    parameter int RET_W     = DEF_RET_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   cyc_sel,
    input  logic               long_mode,
    input  logic               irq_en,
    input  logic               irq_clr,
    input  logic [RET_W-1:0]   key_ret,
    output logic [STROBES-1:0] strobe,
    output logic               irq_n,
    output logic               key_seen
);

    localparam int CNT_W = cnt_bits(BASE_SLOT);

    scan_cfg_t        cfg_in;
    scan_cfg_t        cfg_act;
    logic [CNT_W-1:0] slot_last;
    logic             slot_end;
    logic             cycle_end;

    assign cfg_in.sel       = cyc_sel;
    assign cfg_in.long_mode = long_mode;

    ks_cfg_stage #(.BASE_SLOT(BASE_SLOT), .CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_in    (cfg_in),
        .cycle_end (cycle_end),
        .cfg_act   (cfg_act),
        .slot_last (slot_last)
    );

    ks_slot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .slot_last (slot_last),
        .slot_end  (slot_end)
    );

    ks_strobe_ring #(.STROBES(STROBES)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .slot_end  (slot_end),
        .strobe    (strobe),
        .cycle_end (cycle_end)
    );

    ks_key_latch #(.RET_W(RET_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .slot_end (slot_end),
        .key_ret  (key_ret),
        .irq_clr  (irq_clr),
        .irq_en   (irq_en),
        .key_seen (key_seen),
        .irq_n    (irq_n)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (strobe[0] && !key_seen && irq_n)); // R1

    AST_MASKED_IRQ: assert property (@(posedge clk) disable iff (rst)
        (key_seen && irq_en) |-> !irq_n); // R10

endmodule

// File: tb/keyscan_gen_tb.sv
`timescale 1ns/1ps
module keyscan_gen_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] cyc_sel;
    logic       long_mode;
    logic       irq_en;
    logic       irq_clr;
    logic [3:0] key_ret;
    logic [7:0] strobe;
    logic       irq_n;
    logic       key_seen;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    keyscan_gen u_dut (
        .clk(clk), .rst(rst), .cyc_sel(cyc_sel), .long_mode(long_mode),
        .irq_en(irq_en), .irq_clr(irq_clr), .key_ret(key_ret),
        .strobe(strobe), .irq_n(irq_n), .key_seen(key_seen)
    );

    function automatic int exp_slot(input logic [1:0] s, input logic m);
        return 20 << (int'(s) + int'(m));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] cur_sel, nxt_sel;
        logic       cur_mode, nxt_mode;
        int         width, cyc_sum, len, seed;
        logic [7:0] prev;
        bit         exp_flag, exp_next;

        seed = 7;
        void'($urandom(seed));
        rst = 1; cyc_sel = 2'd0; long_mode = 0; irq_en = 1; irq_clr = 0; key_ret = '0;
        cur_sel = 2'd0; cur_mode = 0;
        repeat (3) @(negedge clk);
        chk(strobe == 8'h01, "R1 strobe in reset", strobe, 1);
        chk(key_seen == 0, "R1 key_seen in reset", key_seen, 0);
        chk(irq_n == 1, "R1 irq_n in reset", irq_n, 1);
        rst = 0;

        // timing: random configuration, changed during line 3
        nxt_sel = cur_sel; nxt_mode = cur_mode;
        for (int cyc = 0; cyc < 12; cyc++) begin
            len = exp_slot(cur_sel, cur_mode);
            cyc_sum = 0;
            for (int ln = 0; ln < 8; ln++) begin
                chk(strobe == (8'h01 << ln), "R2 strobe order", strobe, 1 << ln);
                width = 0;
                do begin
                    width++;
                    if (ln == 3 && width == 2) begin
                        if (cyc == 0) begin
                            nxt_sel = 2'd3; nxt_mode = 1;
                        end else begin
                            nxt_sel  = 2'($urandom_range(0, 3));
                            nxt_mode = 1'($urandom_range(0, 1));
                        end
                        cyc_sel = nxt_sel; long_mode = nxt_mode;
                    end
                    @(negedge clk);
                end while (strobe == (8'h01 << ln) && width < 700);
                cyc_sum += width;
                if (cur_mode)
                    chk(width == len, "R4 slot width mode1 (R6 held)", width, len);
                else
                    chk(width == len, "R3 slot width mode0 (R6 held)", width, len);
            end
            chk(cyc_sum == 8 * len, "R5 cycle length", cyc_sum, 8 * len);
            cur_sel = nxt_sel; cur_mode = nxt_mode;
        end

        // detection, directed; shortest slot
        cyc_sel = 2'd0; long_mode = 0;
        prev = strobe;
        while (!(strobe == 8'h01 && prev == 8'h80)) begin
            prev = strobe; @(negedge clk);
        end
        len = 20;
        width = 1;
        repeat (4) begin @(negedge clk); width++; end
        key_ret = 4'b0100;
        @(negedge clk); width++;
        key_ret = '0;
        while (width <= len + 1) begin @(negedge clk); width++; end
        chk(key_seen == 0, "R8 mid-slot return ignored", key_seen, 0);
        chk(irq_n == 1, "R8 irq after ignored return", irq_n, 1);
        width = width - len;
        while (width < len) begin @(negedge clk); width++; end
        key_ret = 4'b1000;
        @(negedge clk);
        key_ret = '0;
        chk(key_seen == 1, "R7 slot-end sample sets flag", key_seen, 1);
        chk(irq_n == 0, "R10 irq low when enabled", irq_n, 0);
        irq_en = 0; #1;
        chk(irq_n == 1, "R10 irq masked", irq_n, 1);
        chk(key_seen == 1, "R10 mask keeps flag", key_seen, 1);
        irq_en = 1;
        repeat (30) @(negedge clk);
        chk(key_seen == 1, "R9 flag held", key_seen, 1);
        irq_clr = 1; @(negedge clk); irq_clr = 0;
        chk(key_seen == 0, "R9 clear", key_seen, 0);
        chk(irq_n == 1, "R9 irq released", irq_n, 1);
        prev = strobe;
        while (strobe == prev) @(negedge clk);
        width = 1;
        while (width < len) begin @(negedge clk); width++; end
        key_ret = 4'b0001; irq_clr = 1;
        @(negedge clk);
        key_ret = '0; irq_clr = 0;
        chk(key_seen == 1, "R9 detect wins over clear", key_seen, 1);
        irq_clr = 1; @(negedge clk); irq_clr = 0;

        // detection, random traffic against a flag model
        prev = strobe;
        while (strobe == prev) @(negedge clk);
        prev = strobe; width = 1; exp_flag = key_seen;
        for (int i = 0; i < 3000; i++) begin
            chk(key_seen == exp_flag, "R7/R8/R9 random flag", key_seen, exp_flag);
            chk(irq_n == !(exp_flag && irq_en), "R10 random irq", irq_n, !(exp_flag && irq_en));
            if (width == len) key_ret = ($urandom_range(0, 1) == 1) ? 4'($urandom_range(1, 15)) : '0;
            else key_ret = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(1, 15)) : '0;
            irq_clr = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 31) == 0) irq_en = ~irq_en;
            if (width == len && key_ret != 0) exp_next = 1;
            else if (irq_clr) exp_next = 0;
            else exp_next = exp_flag;
            @(negedge clk);
            exp_flag = exp_next;
            if (strobe != prev) begin width = 1; prev = strobe; end
            else width++;
        end
        key_ret = '0; irq_clr = 0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule